// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a set of maskable interrupt request lines and offers a single winning request to a processor core. Each source owns a small control word: a three-bit priority level, a mask bit and a pending flag. A pending flag latches on a rising edge of the source's request line. Of all pending, unmasked sources, the one with the numerically lowest level wins. Among sources at the same level, the lowest source index wins.

The block keeps one in-service bit per priority level. It offers the winner to the core only when two conditions hold. First, the global block flag must be clear. Second, the winner's level must be strictly more urgent than every level already in service. This lets handlers nest.

When the core accepts, the block does four things:
- it hands over the winner's source index as the vector in the same cycle;
- it clears that source's pending flag;
- it marks the level as in service;
- it sets the global block flag automatically.

A handler that wants to be interrupted must clear that flag itself. End-of-service retires the most urgent in-service level. This returns the controller to the level that was preempted.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset every control word reads as level 7, mask 1, pending 0 (value 5'b01111). No level is in service, the global block flag is 1, and `int_req` is 0.
- R2: Control word layout is bits [2:0] level, bit 3 mask, bit 4 pending. A write to the source selected by `cfg_wsel` takes effect on the next clock edge and replaces all three fields. `cfg_rdata` shows the word selected by `cfg_rsel` without delay.
- R3: A 0-to-1 change of `irq_req[i]` between two consecutive clock edges sets pending of source i, whatever its mask. This set wins over a same-cycle write or acknowledge clear. A line held high does not set pending again.
- R4: A source with mask 1 is never offered on `int_req`/`int_vec`.
- R5: Among pending unmasked sources, the offered one has the lowest level value. Among equal levels, it has the lowest source index. `int_lvl` shows its level.
- R6: `int_req` is 1 only when these three hold:
  - a pending unmasked source exists;
  - the global block flag is 0;
  - the winner's level value is strictly less than every level whose in-service bit is set.
- R7: When `int_ack` is 1 while `int_req` is 1, `int_vec` in that cycle is the accepted source. After the clock edge, three things hold:
  - that source's pending flag is 0, unless R3 sets it again;
  - the in-service bit of its level is 1;
  - the global block flag is 1.
- R8: A `svc_done` pulse clears the lowest-numbered set in-service bit. If an acceptance happens in the same cycle, its level bit is then set.
- R9: `irq_disable` sets the global block flag and `irq_enable` clears it. If both are 1, disable wins. An acceptance in the same cycle always leaves the flag at 1.
- R10: `int_ack` while `int_req` is 0 changes no in-service bit, no pending flag and no block flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Request lines, one per source |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wsel | input | SW | Source selected for write |
| cfg_wdata | input | PRIO_W+2 | Control word to write {pending, mask, level} |
| cfg_rsel | input | SW | Source selected for read |
| cfg_rdata | output | PRIO_W+2 | Control word of the read-selected source |
| int_req | output | 1 | Interrupt offered to the core |
| int_vec | output | SW | Source index of the offered interrupt |
| int_lvl | output | PRIO_W | Level of the offered interrupt |
| int_ack | input | 1 | Core accepts the offered interrupt |
| svc_done | input | 1 | End of service of the current handler |
| irq_enable | input | 1 | Clear the global block flag |
| irq_disable | input | 1 | Set the global block flag |
| irq_blocked | output | 1 | Global block flag |
| isr_level | output | 8 | In-service bit per level, bit 0 most urgent |

## Verification
Directed sequences exercise the main arbitration and nesting paths:
- Two sources at the same level separate the index tie-break from the level comparison.
- A third source at a more urgent level then shows that level outranks index.
- A second acceptance attempted with the block flag still set shows the automatic disable.
- A re-enable with only a less urgent source pending shows the strict preemption rule.
- A following end-of-service shows the stack pop that lets the waiting request through.
- Masking the current winner shows that the next candidate is selected.
- A line held high across a pending clear shows edge-only latching.

A long stretch of random toggling on the request lines, random control writes and random pulses follows. The pulses are acknowledge, end-of-service, enable and disable. Every output is compared each cycle with a bench model, which reaches the deep nesting and same-cycle collisions.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam int unsigned PRIO_W = 3;
  localparam int unsigned NLVL   = 1 << PRIO_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [NLVL-1:0]   lvlvec_t;

  // control word: {pend, mask, prio}
  typedef struct packed {
    logic  pend;
    logic  mask;
    prio_t prio;
  } ctrl_t;

  // isolate the most urgent (lowest index) set bit
  function automatic lvlvec_t lowest_set(lvlvec_t v);
    return v & (~v + lvlvec_t'(1));
  endfunction

  // index of the most urgent in-service level, NLVL when none
  function automatic logic [PRIO_W:0] top_level(lvlvec_t v);
    logic [PRIO_W:0] r;
    r = (PRIO_W+1)'(NLVL);
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (v[i]) r = (PRIO_W+1)'(i);
    end
    return r;
  endfunction

  // one bit per level from 0 up to and including p
  function automatic lvlvec_t at_or_above(prio_t p);
    lvlvec_t r;
    for (int i = 0; i < NLVL; i++) begin
      r[i] = (i <= int'(p));
    end
    return r;
  endfunction

  function automatic lvlvec_t lvl_onehot(prio_t p);
    return lvlvec_t'(1) << p;
  endfunction

  // strictly more urgent than the current service level
  function automatic logic outranks(prio_t p, logic [PRIO_W:0] cur);
    return {1'b0, p} < cur;
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC = 16,
  localparam int unsigned SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          req_in,
  input  logic                     wr_en,
  input  logic [SW-1:0]            wr_sel,
  input  ctrl_t                    wr_data,
  input  logic [SW-1:0]            rd_sel,
  output ctrl_t                    rd_data,
  input  logic                     clr_en,
  input  logic [SW-1:0]            clr_sel,
  output logic [NSRC-1:0]          pend_vec,
  output logic [NSRC-1:0]          mask_vec,
  output logic [NSRC*PRIO_W-1:0]   prio_flat
);

  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] rise;
  ctrl_t           regs [NSRC];

  assign rise = req_in & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_in;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic hit_w;
    logic hit_c;
    logic pn;

    assign hit_w = wr_en  && (wr_sel  == SW'(i));
    assign hit_c = clr_en && (clr_sel == SW'(i));

    // order: acknowledge clear, then write, then rising edge wins
    always_comb begin
      pn = regs[i].pend;
      if (hit_c)   pn = 1'b0;
      if (hit_w)   pn = wr_data.pend;
      if (rise[i]) pn = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[i].pend <= 1'b0;
        regs[i].mask <= 1'b1;
        regs[i].prio <= '1;
      end else begin
        regs[i].pend <= pn;
        if (hit_w) begin
          regs[i].mask <= wr_data.mask;
          regs[i].prio <= wr_data.prio;
        end
      end
    end

    assign pend_vec[i]                  = regs[i].pend;
    assign mask_vec[i]                  = regs[i].mask;
    assign prio_flat[i*PRIO_W +: PRIO_W] = regs[i].prio;
  end

  assign rd_data = regs[rd_sel];

  // R3: a rising request edge always leaves the pending flag set
  a_r3_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_vec & $past(rise)) == $past(rise)));

  // R2: a write lands in the selected word one edge later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs[$past(wr_sel)].mask == $past(wr_data.mask)) &&
              (regs[$past(wr_sel)].prio == $past(wr_data.prio)));

endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC = 16,
  localparam int unsigned SW     = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int unsigned LEAVES = 1 << SW
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   win_v,
  output prio_t                  win_lvl,
  output logic [SW-1:0]          win_idx
);

  // heap-ordered tree: node k has children 2k and 2k+1, leaves at LEAVES..2*LEAVES-1
  logic          nv [1:2*LEAVES-1];
  prio_t         nl [1:2*LEAVES-1];
  logic [SW-1:0] ni [1:2*LEAVES-1];

  // the left child carries the lower source indices, so it keeps ties
  function automatic logic keep_left(logic vl, prio_t pl, logic vr, prio_t pr);
    return vl && (!vr || (pl <= pr));
  endfunction

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < NSRC) begin : g_real
      assign nv[LEAVES+j] = cand[j];
      assign nl[LEAVES+j] = prio_flat[j*PRIO_W +: PRIO_W];
    end else begin : g_pad
      assign nv[LEAVES+j] = 1'b0;
      assign nl[LEAVES+j] = '1;
    end
    assign ni[LEAVES+j] = SW'(j);
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    logic lw;
    assign lw    = keep_left(nv[2*k], nl[2*k], nv[2*k+1], nl[2*k+1]);
    assign nv[k] = nv[2*k] | nv[2*k+1];
    assign nl[k] = lw ? nl[2*k] : nl[2*k+1];
    assign ni[k] = lw ? ni[2*k] : ni[2*k+1];
  end

  assign win_v   = nv[1];
  assign win_lvl = nl[1];
  assign win_idx = ni[1];

endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
  import irq_nest_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  prio_t           take_lvl,
  input  logic            eoi,
  input  logic            ei,
  input  logic            di,
  output lvlvec_t         isr,
  output logic            gdis,
  output logic [PRIO_W:0] cur_lvl
);

  lvlvec_t isr_nx;
  logic    gdis_nx;

  // pop the most urgent level first, then push the accepted one
  always_comb begin
    isr_nx = isr & ~(eoi ? lowest_set(isr) : lvlvec_t'(0));
    if (take) isr_nx = isr_nx | lvl_onehot(take_lvl);
  end

  always_comb begin
    gdis_nx = gdis;
    if (ei)   gdis_nx = 1'b0;
    if (di)   gdis_nx = 1'b1;
    if (take) gdis_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr  <= '0;
      gdis <= 1'b1;
    end else begin
      isr  <= isr_nx;
      gdis <= gdis_nx;
    end
  end

  assign cur_lvl = top_level(isr);

  // R7: acceptance marks its level in service and blocks further acceptance
  a_r7_take_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> isr[$past(take_lvl)] && gdis);

  // R8: a lone end-of-service retires exactly one level
  a_r8_eoi_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !take && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R9: enable without disable or acceptance clears the block flag
  a_r9_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ei && !di && !take) |=> !gdis);

  // R9: disable always leaves the block flag set
  a_r9_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    di |=> gdis);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC = 16,
  localparam int unsigned SW     = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int unsigned CTRL_W = PRIO_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_wsel,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic [SW-1:0]     cfg_rsel,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              int_req,
  output logic [SW-1:0]     int_vec,
  output logic [PRIO_W-1:0] int_lvl,
  input  logic              int_ack,
  input  logic              svc_done,
  input  logic              irq_enable,
  input  logic              irq_disable,
  output logic              irq_blocked,
  output logic [NLVL-1:0]   isr_level
);

  logic [NSRC-1:0]        pend_vec;
  logic [NSRC-1:0]        mask_vec;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]        cand;
  ctrl_t                  rd_word;
  logic                   win_v;
  prio_t                  win_lvl;
  logic [SW-1:0]          win_idx;
  logic                   take;
  lvlvec_t                isr;
  logic                   gdis;
  logic [PRIO_W:0]        cur_lvl;

  irq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (irq_req),
    .wr_en     (cfg_we),
    .wr_sel    (cfg_wsel),
    .wr_data   (ctrl_t'(cfg_wdata)),
    .rd_sel    (cfg_rsel),
    .rd_data   (rd_word),
    .clr_en    (take),
    .clr_sel   (win_idx),
    .pend_vec  (pend_vec),
    .mask_vec  (mask_vec),
    .prio_flat (prio_flat)
  );

  assign cand = pend_vec & ~mask_vec;

  irq_pick_tree #(.NSRC(NSRC)) u_pick (
    .cand      (cand),
    .prio_flat (prio_flat),
    .win_v     (win_v),
    .win_lvl   (win_lvl),
    .win_idx   (win_idx)
  );

  irq_svc_stack u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_lvl (win_lvl),
    .eoi      (svc_done),
    .ei       (irq_enable),
    .di       (irq_disable),
    .isr      (isr),
    .gdis     (gdis),
    .cur_lvl  (cur_lvl)
  );

  assign int_req     = win_v && !gdis && outranks(win_lvl, cur_lvl);
  assign take        = int_ack && int_req;
  assign int_vec     = win_idx;
  assign int_lvl     = win_lvl;
  assign cfg_rdata   = rd_word;
  assign irq_blocked = gdis;
  assign isr_level   = isr;

  // R4: only a pending, unmasked source is offered
  a_r4_offer_is_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (!mask_vec[int_vec] && pend_vec[int_vec]));

  // R6: the offer is strictly more urgent than every level in service
  a_r6_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (((isr & at_or_above(int_lvl)) == '0) && !gdis));

  // R10: acknowledge with nothing offered leaves the service state alone
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req && !svc_done && !irq_enable && !irq_disable)
      |=> ($stable(isr) && $stable(gdis)));

  // R5: no candidate beats the winner on level, nor on index at equal level
  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r5_no_better_source: assert property (@(posedge clk) disable iff (!rst_n)
      (win_v && cand[i]) |->
        ((prio_flat[i*PRIO_W +: PRIO_W] > win_lvl) ||
         ((prio_flat[i*PRIO_W +: PRIO_W] == win_lvl) && (SW'(i) >= win_idx))));
  end

endmodule

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] b_req = '0;
  logic        b_we = 1'b0;
  logic [3:0]  b_wsel = '0;
  logic [4:0]  b_wdata = '0;
  logic [3:0]  b_rsel = '0;
  logic [4:0]  cfg_rdata;
  logic        int_req;
  logic [3:0]  int_vec;
  logic [2:0]  int_lvl;
  logic        b_ack = 1'b0;
  logic        b_eoi = 1'b0;
  logic        b_ei = 1'b0;
  logic        b_di = 1'b0;
  logic        blocked;
  logic [7:0]  isr_level;

  always #4 clk = ~clk;  // 125 MHz

  irq_nest_ctrl #(.NSRC(16)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(b_req),
    .cfg_we(b_we), .cfg_wsel(b_wsel), .cfg_wdata(b_wdata),
    .cfg_rsel(b_rsel), .cfg_rdata(cfg_rdata),
    .int_req(int_req), .int_vec(int_vec), .int_lvl(int_lvl),
    .int_ack(b_ack), .svc_done(b_eoi), .irq_enable(b_ei), .irq_disable(b_di),
    .irq_blocked(blocked), .isr_level(isr_level)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int unsigned m_lvl [16];
  bit          m_msk [16];
  bit          m_pnd [16];
  bit [7:0]    m_isr;
  bit          m_gdis;
  bit [15:0]   m_prev;

  task automatic chk(string tag, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_lvl[i] = 7; m_msk[i] = 1; m_pnd[i] = 0;
    end
    m_isr = '0; m_gdis = 1; m_prev = '0;
  endtask

  // one clock: compare outputs, advance model, clear pulses; starts and ends at negedge
  task automatic step();
    int wv, wi, wl, cur;
    bit ereq, take;
    bit [7:0] n_isr;
    bit n_gdis;
    bit n_pnd [16];
    #1;
    wv = 0; wi = 0; wl = 8;
    for (int i = 0; i < 16; i++)
      if (m_pnd[i] && !m_msk[i] && int'(m_lvl[i]) < wl) begin wv = 1; wi = i; wl = m_lvl[i]; end
    cur = 8;
    for (int l = 7; l >= 0; l--) if (m_isr[l]) cur = l;
    ereq = (wv != 0) && !m_gdis && (wl < cur);
    chk("R6", "int_req", int_req, ereq);
    if (ereq) begin
      chk("R5", "int_vec", int_vec, wi);
      chk("R5", "int_lvl", int_lvl, wl);
    end
    chk("R9", "irq_blocked", blocked, m_gdis);
    chk("R8", "isr_level", isr_level, m_isr);
    chk("R2", "cfg_rdata", cfg_rdata, {m_pnd[b_rsel], m_msk[b_rsel], 3'(m_lvl[b_rsel])});
    take = b_ack && ereq;
    for (int i = 0; i < 16; i++) begin
      n_pnd[i] = m_pnd[i];
      if (take && wi == i) n_pnd[i] = 0;
      if (b_we && b_wsel == 4'(i)) n_pnd[i] = b_wdata[4];
      if (b_req[i] && !m_prev[i]) n_pnd[i] = 1;
    end
    n_isr = m_isr;
    if (b_eoi)
      for (int l = 0; l < 8; l++) if (m_isr[l]) begin n_isr[l] = 0; break; end
    if (take) n_isr[wl] = 1;
    n_gdis = m_gdis;
    if (b_ei) n_gdis = 0;
    if (b_di) n_gdis = 1;
    if (take) n_gdis = 1;
    @(posedge clk);
    for (int i = 0; i < 16; i++) m_pnd[i] = n_pnd[i];
    if (b_we) begin m_msk[b_wsel] = b_wdata[3]; m_lvl[b_wsel] = b_wdata[2:0]; end
    m_isr = n_isr; m_gdis = n_gdis; m_prev = b_req;
    @(negedge clk);
    b_we = 0; b_ack = 0; b_eoi = 0; b_ei = 0; b_di = 0;
  endtask

  task automatic wr(int src, bit p, bit m, int lvl);
    b_we = 1; b_wsel = 4'(src); b_wdata = {p, m, 3'(lvl)};
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state of every control word and the service state
    for (int i = 0; i < 16; i++) begin
      b_rsel = 4'(i); #1;
      chk("R1", "reset word", cfg_rdata, 5'b01111);
    end
    chk("R1", "reset int_req", int_req, 0);
    chk("R1", "reset blocked", blocked, 1);
    chk("R1", "reset isr", isr_level, 0);
    @(negedge clk);

    wr(3, 0, 0, 2);
    wr(9, 0, 0, 2);
    wr(12, 0, 0, 1);
    b_ei = 1; step();
    chk("R9", "enable clears", blocked, 0);

    // R5: equal level, lower index wins
    b_req[3] = 1; b_req[9] = 1; step();
    #1;
    chk("R5", "tie int_req", int_req, 1);
    chk("R5", "tie vec", int_vec, 3);
    @(negedge clk);

    // R5: more urgent level beats lower index
    b_req[12] = 1; step();
    #1;
    chk("R5", "level vec", int_vec, 12);
    chk("R5", "level lvl", int_lvl, 1);
    @(negedge clk);

    // R7: acceptance
    b_ack = 1; step();
    b_rsel = 12; #1;
    chk("R7", "blocked after ack", blocked, 1);
    chk("R7", "isr after ack", isr_level, 8'b0000_0010);
    chk("R7", "pending cleared", cfg_rdata[4], 0);
    @(negedge clk);

    // R10: acknowledge with nothing offered
    b_ack = 1; step();
    b_rsel = 3; #1;
    chk("R10", "isr unchanged", isr_level, 8'b0000_0010);
    chk("R10", "pending kept", cfg_rdata[4], 1);
    chk("R10", "blocked kept", blocked, 1);
    @(negedge clk);

    // R6: level 2 cannot preempt level 1
    b_ei = 1; step();
    #1;
    chk("R6", "no preempt", int_req, 0);
    @(negedge clk);

    // R8: end of service releases the waiting request
    b_eoi = 1; step();
    #1;
    chk("R8", "isr popped", isr_level, 0);
    chk("R8", "released req", int_req, 1);
    chk("R8", "released vec", int_vec, 3);
    @(negedge clk);

    // R4: masked winner is skipped
    wr(3, 1, 1, 2);
    #1;
    chk("R4", "masked skipped", int_vec, 9);
    @(negedge clk);

    // R3: edge latches on a masked source, held level does not relatch
    b_req[5] = 1; step();
    b_rsel = 5; #1;
    chk("R3", "edge latched", cfg_rdata[4], 1);
    chk("R4", "masked not offered", int_vec, 9);
    @(negedge clk);
    wr(5, 0, 1, 7);
    b_rsel = 5; #1;
    chk("R3", "no relatch", cfg_rdata[4], 0);
    @(negedge clk);

    // random phase against the model
    for (int c = 0; c < 6000; c++) begin
      b_req  = b_req ^ 16'($urandom & $urandom & $urandom);
      b_rsel = 4'($urandom);
      if (($urandom % 8) == 0) begin
        b_we = 1; b_wsel = 4'($urandom); b_wdata = 5'($urandom);
      end
      b_ack = ($urandom % 2) == 0;
      b_eoi = ($urandom % 6) == 0;
      b_ei  = ($urandom % 4) == 0;
      b_di  = ($urandom % 16) == 0;
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule